// File: doc/BRIEF.md
# Transmit Control Register File

This block is the processor-facing register file of a one-way serial packet transmitter. It sits on an 8-bit data bus with a 16-bit address. It decodes a window of eight addresses at the very top of the address space. Writes in that window load a 16-bit channel-select pattern that chooses which receivers get the next packet. Writes also set a control byte, which carries a start flag and an interrupt-on-completion enable, and hand the two packet bytes to the shifter through one-cycle load strobes.

The control byte cannot be read at the address where it is written. Software reads it back through a separate status address instead. When the shifter finishes, it pulses a done input, and the hardware then clears the start flag. Software can therefore poll bit 0 of the status byte until it reads 0. The serial shifting, the bit clock and any level translation belong to neighbouring blocks.

Top module: `txctl_regs`

## Requirements
- R1: A register is selected only when address bits 15 to 3 are all 1. Bus writes anywhere else change no output and produce no strobe.
- R2: A write at offset 0 sets `chan_sel[7:0]` and a write at offset 1 sets `chan_sel[15:8]`. The new value is visible after the write's clock edge, and any bit pattern can be held.
- R3: A write at offset 2 loads the whole control byte. Bit 0 drives `ctl_start` and bit 1 drives `ctl_irq_en`.
- R4: A write at offset 3 gives a single-cycle `pkt_lo_load` and a write at offset 4 gives a single-cycle `pkt_hi_load`. In the cycle after the write edge, `pkt_data` carries the written byte. At most one of the two strobes is high at a time.
- R5: A read at offset 5 raises `bus_oe` for one cycle after the read edge. In that cycle `bus_rdata` holds the full control byte as it stood at the read edge.
- R6: When `bus_oe` is low, `bus_rdata` is zero. Reads at offsets 0 to 4, 6 and 7, and reads outside the window, never raise `bus_oe`.
- R7: A `tx_done` pulse clears control bit 0 and leaves bits 7 to 1 unchanged.
- R8: If `tx_done` arrives in the same cycle as a control write, the written byte is kept unchanged, including its bit 0.
- R9: Writes at offsets 5, 6 and 7 change no register and produce no strobe.
- R10: A synchronous active-high reset clears the channel selects and the control byte, and drops all strobes and `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_re | input | 1 | Read strobe, sampled at the clock edge |
| bus_rdata | output | 8 | Read data, zero unless `bus_oe` is high |
| bus_oe | output | 1 | Read data valid / bus drive enable |
| tx_done | input | 1 | Completion pulse from the shifter |
| chan_sel | output | 16 | One select bit per receiving channel |
| ctl_start | output | 1 | Start flag (control bit 0) |
| ctl_irq_en | output | 1 | Interrupt-on-completion enable (control bit 1) |
| pkt_lo_load | output | 1 | Load strobe for the packet low byte |
| pkt_hi_load | output | 1 | Load strobe for the packet high byte |
| pkt_data | output | 8 | Byte carried with a load strobe |

## Verification
The bench probes the edges of the decode window. It writes to addresses where only bit 3 or only bit 15 is low. A decoder that compares too few upper bits would then corrupt the channel selects or fire a stray strobe. It writes the status offset and the unused offsets. A design that aliased them onto the control register would change the byte read back afterwards. It pulses done against a control byte with high bits set, and also in the same cycle as a control write. A wrong mask would lose the upper bits, and wrong priority would leave bit 0 cleared where the write should have set it.

// File: rtl/txctl_pkg.sv
package txctl_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  localparam int NREG    = 1 << SEL_W;
  localparam int N_DEST  = 2;

  // register offsets inside the decoded window
  localparam int OFF_DEST0  = 0;
  localparam int OFF_DEST1  = 1;
  localparam int OFF_CTRL   = 2;
  localparam int OFF_PKT_LO = 3;
  localparam int OFF_PKT_HI = 4;
  localparam int OFF_STAT   = 5;

  // control byte fields
  localparam int CTL_START_BIT = 0;
  localparam int CTL_IRQ_BIT   = 1;
endpackage

// File: rtl/txctl_decode.sv
module txctl_decode #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    en,
  output logic [(1<<SEL_W)-1:0]   sel
);
  localparam int NREG = 1 << SEL_W;

  logic hit;
  assign hit = &addr[ADDR_W-1:SEL_W];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = en && hit && (addr[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    assert_sel_onehot_R1: assert ($onehot0(sel));
  end
endmodule

// File: rtl/txctl_dest.sv
module txctl_dest #(
  parameter int DATA_W = 8,
  parameter int N_DEST = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [N_DEST-1:0]        wr,
  output logic [N_DEST*DATA_W-1:0] chan_sel
);
  for (genvar b = 0; b < N_DEST; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)        chan_sel[b*DATA_W +: DATA_W] <= '0;
      else if (wr[b]) chan_sel[b*DATA_W +: DATA_W] <= wdata;
    end
  end

  assert_dest_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr == '0) |=> $stable(chan_sel));
endmodule

// File: rtl/txctl_ctrl.sv
module txctl_ctrl #(
  parameter int DATA_W    = 8,
  parameter int START_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              done,
  input  logic              rd,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  localparam logic [DATA_W-1:0] START_MASK = DATA_W'(1) << START_BIT;

  // CPU write has priority over the hardware clear
  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (wr)   ctrl_q <= wdata;
    else if (done) ctrl_q <= ctrl_q & ~START_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      oe    <= 1'b0;
    end else begin
      rdata <= rd ? ctrl_q : '0;
      oe    <= rd;
    end
  end

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !wr) |=> (!ctrl_q[START_BIT] &&
      ((ctrl_q & ~START_MASK) == ($past(ctrl_q) & ~START_MASK))));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && done) |=> (ctrl_q == $past(wdata)));

  assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (rdata == '0));
endmodule

// File: rtl/txctl_regs.sv
module txctl_regs
  import txctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_oe,
  input  logic                     tx_done,
  output logic [N_DEST*DATA_W-1:0] chan_sel,
  output logic                     ctl_start,
  output logic                     ctl_irq_en,
  output logic                     pkt_lo_load,
  output logic                     pkt_hi_load,
  output logic [DATA_W-1:0]        pkt_data
);
  logic [NREG-1:0]   wsel;
  logic [NREG-1:0]   rsel;
  logic [DATA_W-1:0] ctrl_q;

  txctl_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_wdec (
    .addr(bus_addr), .en(bus_we), .sel(wsel));

  txctl_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_rdec (
    .addr(bus_addr), .en(bus_re), .sel(rsel));

  txctl_dest #(.DATA_W(DATA_W), .N_DEST(N_DEST)) u_dest (
    .clk(clk), .rst(rst), .wdata(bus_wdata),
    .wr(wsel[OFF_DEST0 +: N_DEST]), .chan_sel(chan_sel));

  txctl_ctrl #(.DATA_W(DATA_W), .START_BIT(CTL_START_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .wdata(bus_wdata), .wr(wsel[OFF_CTRL]),
    .done(tx_done), .rd(rsel[OFF_STAT]), .ctrl_q(ctrl_q),
    .rdata(bus_rdata), .oe(bus_oe));

  assign ctl_start  = ctrl_q[CTL_START_BIT];
  assign ctl_irq_en = ctrl_q[CTL_IRQ_BIT];

  // packet byte hand-off, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_lo_load <= 1'b0;
      pkt_hi_load <= 1'b0;
      pkt_data    <= '0;
    end else begin
      pkt_lo_load <= wsel[OFF_PKT_LO];
      pkt_hi_load <= wsel[OFF_PKT_HI];
      pkt_data    <= (wsel[OFF_PKT_LO] || wsel[OFF_PKT_HI]) ? bus_wdata : '0;
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_lo_load, pkt_hi_load}));

  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !(&bus_addr[ADDR_W-1:SEL_W]) |=> (!pkt_lo_load && !pkt_hi_load && !bus_oe));
endmodule

// File: tb/txctl_regs_tb.sv
`timescale 1ns/100ps
module txctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_oe;
  logic        tx_done = 1'b0;
  logic [15:0] chan_sel;
  logic        ctl_start, ctl_irq_en, pkt_lo_load, pkt_hi_load;
  logic [7:0]  pkt_data;

  int errors = 0;
  int checks = 0;
  bit live = 1'b0;
  bit finished = 1'b0;

  logic [7:0] rd_q[$];
  logic [8:0] ld_q[$];
  logic [7:0]  m_ctrl = '0;
  logic [15:0] m_sel = '0;

  always #2.5 clk = ~clk;

  txctl_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .tx_done(tx_done), .chan_sel(chan_sel), .ctl_start(ctl_start),
    .ctl_irq_en(ctl_irq_en), .pkt_lo_load(pkt_lo_load),
    .pkt_hi_load(pkt_hi_load), .pkt_data(pkt_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return &a[15:3];
  endfunction

  // driver: one write, expected results pushed into the model/queues
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit done);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tx_done = done;
    if (done) m_ctrl[0] = 1'b0;
    if (in_win(a)) begin
      case (a[2:0])
        3'd0: m_sel[7:0]  = d;
        3'd1: m_sel[15:8] = d;
        3'd2: m_ctrl      = d;
        3'd3: ld_q.push_back({1'b0, d});
        3'd4: ld_q.push_back({1'b1, d});
        default: ;
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0; tx_done = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    if (in_win(a) && a[2:0] == 3'd5) rd_q.push_back(m_ctrl);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    tx_done = 1'b1; m_ctrl[0] = 1'b0;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    @(negedge clk);
    chk(chan_sel == m_sel, req, chan_sel, m_sel);
    chk(ctl_start == m_ctrl[0], req, ctl_start, m_ctrl[0]);
    chk(ctl_irq_en == m_ctrl[1], req, ctl_irq_en, m_ctrl[1]);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (live) begin
      if (bus_oe) begin
        if (rd_q.size() == 0) chk(1'b0, "R6 unexpected read data", bus_rdata, 0);
        else begin
          logic [7:0] e;
          e = rd_q.pop_front();
          chk(bus_rdata == e, "R5 status read", bus_rdata, e);
        end
      end else begin
        chk(bus_rdata == 8'h00, "R6 idle read data", bus_rdata, 0);
      end
      if (pkt_lo_load || pkt_hi_load) begin
        if (ld_q.size() == 0)
          chk(1'b0, "R4 unexpected strobe", {pkt_hi_load, pkt_data}, 0);
        else begin
          logic [8:0] e;
          e = ld_q.pop_front();
          chk(!(pkt_lo_load && pkt_hi_load) && pkt_hi_load == e[8] && pkt_data == e[7:0],
              "R4 packet load", {pkt_hi_load, pkt_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    // R10 reset state
    @(negedge clk);
    chk(chan_sel == 16'h0, "R10 chan_sel", chan_sel, 0);
    chk({ctl_start, ctl_irq_en, pkt_lo_load, pkt_hi_load, bus_oe} == 5'b0,
        "R10 flags", {ctl_start, ctl_irq_en, pkt_lo_load, pkt_hi_load, bus_oe}, 0);
    bus_read(16'hFFFD);

    // R2 destinations, several patterns
    bus_write(16'hFFF8, 8'hA5, 1'b0);
    bus_write(16'hFFF9, 8'h3C, 1'b0);
    check_outputs("R2 dest A5/3C");
    bus_write(16'hFFF8, 8'hFF, 1'b0);
    bus_write(16'hFFF9, 8'h00, 1'b0);
    check_outputs("R2 dest FF/00");
    bus_write(16'hFFF9, 8'h81, 1'b0);
    check_outputs("R2 dest high only");

    // R1 decode edges: bit 3 low, bit 15 low, mid address
    bus_write(16'hFFF0, 8'h12, 1'b0);
    bus_write(16'h7FF8, 8'h34, 1'b0);
    bus_write(16'hFFF3, 8'h56, 1'b0);
    bus_write(16'h7FFC, 8'h9A, 1'b0);
    bus_write(16'hFFF2, 8'h55, 1'b0);
    check_outputs("R1 outside window ignored");
    bus_write(16'h0002, 8'h00, 1'b0);
    check_outputs("R1 low address ignored");
    bus_read(16'hFFFD);

    // R3 control write
    bus_write(16'hFFFA, 8'h03, 1'b0);
    check_outputs("R3 start+irq");
    bus_read(16'hFFFD);
    bus_write(16'hFFFA, 8'hC1, 1'b0);
    check_outputs("R3 start only");
    bus_read(16'hFFFD);

    // R4 packet strobes
    bus_write(16'hFFFB, 8'h5A, 1'b0);
    bus_write(16'hFFFC, 8'hE7, 1'b0);
    bus_write(16'hFFFB, 8'h00, 1'b0);
    bus_write(16'hFFFC, 8'hFF, 1'b0);

    // R6 reads at non-status offsets and outside the window
    bus_read(16'hFFF8); bus_read(16'hFFFA); bus_read(16'hFFFB);
    bus_read(16'hFFFE); bus_read(16'hFFFF); bus_read(16'hFFF5);

    // R9 writes to status / unused offsets ignored
    bus_write(16'hFFFD, 8'h00, 1'b0);
    bus_write(16'hFFFE, 8'h00, 1'b0);
    bus_write(16'hFFFF, 8'h00, 1'b0);
    check_outputs("R9 status/unused ignored");
    bus_read(16'hFFFD);

    // R7 done clears bit 0 only
    bus_write(16'hFFFA, 8'hF3, 1'b0);
    pulse_done();
    check_outputs("R7 done clear");
    bus_read(16'hFFFD);
    pulse_done();
    check_outputs("R7 second done no change");

    // R8 write in the same cycle as done wins
    bus_write(16'hFFFA, 8'h07, 1'b1);
    check_outputs("R8 write wins over done");
    bus_read(16'hFFFD);

    // done alongside an unrelated write still clears
    bus_write(16'hFFF8, 8'h11, 1'b1);
    check_outputs("R7 done with dest write");
    bus_read(16'hFFFD);

    repeat (3) @(negedge clk);
    chk(rd_q.size() == 0, "R5 pending reads", rd_q.size(), 0);
    chk(ld_q.size() == 0, "R4 pending loads", ld_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule